// File: doc/BRIEF.md
# Bytecode Stack Machine Executor

This block runs a subset of a one-byte-opcode stack bytecode. It fetches one byte per cycle from an external program memory and decodes each opcode by its numeric range. Most opcodes carry their operand in the low bits of the opcode byte. A few take one extension byte that holds a selector and an index, or the low byte of a jump distance. Values live in an evaluation stack of tagged 16-bit words, with a fixed depth. Four small word arrays supply and receive values: receiver fields, temporaries, literal constants and literal variables. The surrounding logic fills these arrays through a write port before it starts execution.

Execution advances while `run` is high. It stops for good in three cases: an opcode outside the subset (message sends, returns, context access, arithmetic), a stack overflow or underflow, and a malformed operand. After a stop the block waits for reset. The program counter, the stack top, the stack depth and three flags are visible at the ports. A caller can therefore locate the faulting instruction and inspect the final stack.

A word is `{tag[15:14], payload[13:0]}`. The tags are: 00 small integer (two's complement payload), 01 object reference, 10 boolean (payload 1 = true, 0 = false), 11 nil (payload 0).

Top module: `bcExec`

## Requirements
- R1: After reset, `pc` is 0, `stackDepth` is 0, and `halted`, `errFlag` and `unsupFlag` are all low.
- R2: Opcodes 0x00–0x0F push receiver field [op & 0xF]. Opcodes 0x10–0x1F push temporary [op & 0xF]. Opcodes 0x20–0x3F push literal constant [op & 0x1F]. Opcodes 0x40–0x5F push literal variable [op & 0x1F].
- R3: Opcodes 0x70–0x77 push, by op & 7, in this order: `selfWord`, true, false, nil, integer −1, 0, 1, 2, using the tag encoding above.
- R4: Opcodes 0x60–0x67 pop the top into receiver field [op & 7]. Opcodes 0x68–0x6F pop the top into temporary [op & 7].
- R5: Opcodes 0x80 (push), 0x81 (store, top kept) and 0x82 (store and pop) take an extension byte. Its bits [7:6] select the array (0 receiver, 1 temporary, 2 literal constant, 3 literal variable) and its bits [5:0] give the index.
- R6: A store form (0x81/0x82) whose selector is 2 raises `errFlag` and halts, and leaves the stack and `pc` unchanged.
- R7: Opcode 0x87 drops the top. Opcode 0x88 pushes a copy of the top.
- R8: Opcodes 0x90–0x97 jump by (op & 7) + 1. Opcodes 0x98–0x9F pop, then jump by the same distance only when the popped word is false. Distances count from the address after the instruction.
- R9: Opcodes 0xA0–0xA7 jump by ((op & 7) − 4)·256 + ext, a signed distance measured from the address after the extension byte, modulo the program counter width.
- R10: Opcodes 0xA8–0xAB pop and jump by (op & 3)·256 + ext when the word is true. Opcodes 0xAC–0xAF do the same when the word is false. Otherwise execution continues after the extension byte.
- R11: A conditional jump whose popped word is not boolean raises `errFlag` and halts with `pc` on the jump opcode and the stack unchanged.
- R12: A push on a full stack, or a pop, store, duplicate or conditional jump on an empty stack, raises `errFlag` and halts with `pc` on the faulting opcode. Once halted, `pc` and the stack stay frozen until reset.
- R13: Any other opcode (0x78–0x7F, 0x83–0x86, 0x89–0x8F, 0xB0–0xFF) raises `unsupFlag` only, and halts with `pc` on that opcode.
- R14: A one-byte instruction completes in one clock cycle and a two-byte instruction in two. While `run` is low nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Execution enable |
| progAddr | output | 12 | Byte address into program memory |
| progData | input | 8 | Byte at `progAddr`, combinational |
| selfWord | input | 16 | Word pushed by opcode 0x70 |
| loadEn | input | 1 | Array preload strobe |
| loadSel | input | 2 | Preload array (0 receiver, 1 temp, 2 literal constant, 3 literal variable) |
| loadIdx | input | 6 | Preload index |
| loadData | input | 16 | Preload word |
| pc | output | 12 | Address of the next instruction |
| topWord | output | 16 | Stack top (0 when empty) |
| stackDepth | output | 4 | Number of stacked words |
| halted | output | 1 | Execution stopped |
| errFlag | output | 1 | Stack or operand fault |
| unsupFlag | output | 1 | Opcode outside the subset |

## Verification
A decode slip in the opcode-range table shows up at once. The pushed word, the depth step or the next `pc` is wrong on the same cycle the instruction retires. Every short opcode is swept singly and every unsupported opcode is swept, so a single mis-mapped range changes `topWord` or `unsupFlag` for at least one case. Jump-distance errors, such as the wrong bias, a wrong base address or a dropped high bits field, move `pc` to a byte that deliberately holds an unsupported opcode. The run then halts at a visibly wrong address. Flaws in the stack pointer or the fault checks appear as a wrong `stackDepth`, or as a missing or spurious `errFlag` on the cycle of the offending instruction.

// File: rtl/bcPkg.sv
package bcPkg;
  parameter int WORD_W = 16;
  parameter int TAG_W  = 2;
  parameter int PC_W   = 12;
  parameter int IDX_W  = 6;
  localparam int PAY_W = WORD_W - TAG_W;

  typedef logic [WORD_W-1:0] word_t;

  localparam logic [TAG_W-1:0] TAG_INT  = 2'd0;
  localparam logic [TAG_W-1:0] TAG_OBJ  = 2'd1;
  localparam logic [TAG_W-1:0] TAG_BOOL = 2'd2;
  localparam logic [TAG_W-1:0] TAG_NIL  = 2'd3;

  localparam word_t TRUE_W  = {TAG_BOOL, PAY_W'(1)};
  localparam word_t FALSE_W = {TAG_BOOL, PAY_W'(0)};
  localparam word_t NIL_W   = {TAG_NIL,  PAY_W'(0)};

  typedef enum logic [1:0] {SRC_VAR, SRC_CONST, SRC_TOP, SRC_SELF} pushSrc_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic             pcWe;
    logic [PC_W-1:0]  pcStep;
    logic             push;
    logic             pop;
    pushSrc_e         src;
    word_t            constWord;
    logic             arrWe;
    logic [1:0]       arrSel;
    logic [IDX_W-1:0] arrIdx;
  } strobe_t;

  function automatic word_t mkInt(input logic signed [PAY_W-1:0] v);
    return {TAG_INT, v};
  endfunction
endpackage

// File: rtl/bcCtrl.sv
module bcCtrl
  import bcPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic [7:0] progData,
  input  logic       stackEmpty,
  input  logic       stackFull,
  input  word_t      topWord,
  output strobe_t    stb,
  output logic       inExt,
  output logic       halted,
  output logic       errFlag,
  output logic       unsupFlag
);
  typedef enum logic [1:0] {S_OP, S_EXT, S_HALT} state_e;
  state_e state, nextState;
  logic [7:0] opReg, op, ext;
  logic [PC_W-1:0] len, jumpOff;
  logic needPush, needTop, isCond, condWant, illegal, fault, taken;
  logic setErr, setUnsup;

  function automatic logic hasExt(input logic [7:0] b);
    return (b == 8'h80) || (b == 8'h81) || (b == 8'h82) || (b[7:4] == 4'hA);
  endfunction

  assign inExt  = (state == S_EXT);
  assign halted = (state == S_HALT);

  always_comb begin
    stb       = '0;
    nextState = state;
    setErr    = 1'b0;
    setUnsup  = 1'b0;
    needPush  = 1'b0;
    needTop   = 1'b0;
    isCond    = 1'b0;
    condWant  = 1'b0;
    illegal   = 1'b0;
    fault     = 1'b0;
    taken     = 1'b0;
    jumpOff   = '0;
    op        = (state == S_EXT) ? opReg : progData;
    ext       = progData;
    len       = (state == S_EXT) ? PC_W'(2) : PC_W'(1);
    if (run && state != S_HALT) begin
      if (state == S_OP && hasExt(progData)) begin
        nextState = S_EXT;
      end else begin
        nextState = S_OP;
        stb.pcWe  = 1'b1;
        casez (op)
          8'b0000_????: begin needPush = 1'b1; stb.push = 1'b1; stb.src = SRC_VAR;
                              stb.arrSel = 2'd0; stb.arrIdx = IDX_W'(op[3:0]); end
          8'b0001_????: begin needPush = 1'b1; stb.push = 1'b1; stb.src = SRC_VAR;
                              stb.arrSel = 2'd1; stb.arrIdx = IDX_W'(op[3:0]); end
          8'b001?_????: begin needPush = 1'b1; stb.push = 1'b1; stb.src = SRC_VAR;
                              stb.arrSel = 2'd2; stb.arrIdx = IDX_W'(op[4:0]); end
          8'b010?_????: begin needPush = 1'b1; stb.push = 1'b1; stb.src = SRC_VAR;
                              stb.arrSel = 2'd3; stb.arrIdx = IDX_W'(op[4:0]); end
          8'b0110_????: begin needTop = 1'b1; stb.pop = 1'b1; stb.arrWe = 1'b1;
                              stb.arrSel = {1'b0, op[3]}; stb.arrIdx = IDX_W'(op[2:0]); end
          8'b0111_0???: begin
            needPush = 1'b1; stb.push = 1'b1; stb.src = SRC_CONST;
            case (op[2:0])
              3'd0: stb.src = SRC_SELF;
              3'd1: stb.constWord = TRUE_W;
              3'd2: stb.constWord = FALSE_W;
              3'd3: stb.constWord = NIL_W;
              3'd4: stb.constWord = mkInt(-PAY_W'(1));
              3'd5: stb.constWord = mkInt(PAY_W'(0));
              3'd6: stb.constWord = mkInt(PAY_W'(1));
              default: stb.constWord = mkInt(PAY_W'(2));
            endcase
          end
          8'h80: begin needPush = 1'b1; stb.push = 1'b1; stb.src = SRC_VAR;
                       stb.arrSel = ext[7:6]; stb.arrIdx = ext[5:0]; end
          8'h81, 8'h82: begin
            needTop = 1'b1; stb.arrWe = 1'b1; stb.pop = op[1];
            stb.arrSel = ext[7:6]; stb.arrIdx = ext[5:0];
            illegal = (ext[7:6] == 2'd2);
          end
          8'h87: begin needTop = 1'b1; stb.pop = 1'b1; end
          8'h88: begin needTop = 1'b1; needPush = 1'b1; stb.push = 1'b1; stb.src = SRC_TOP; end
          8'b1001_????: begin
            jumpOff = PC_W'(op[2:0]) + PC_W'(1);
            if (op[3]) begin isCond = 1'b1; condWant = 1'b0; needTop = 1'b1; stb.pop = 1'b1; end
          end
          8'b1010_0???: jumpOff = {{(PC_W-11){~op[2]}}, ~op[2], op[1:0], ext};
          8'b1010_1???: begin
            jumpOff = {{(PC_W-10){1'b0}}, op[1:0], ext};
            isCond = 1'b1; condWant = ~op[2]; needTop = 1'b1; stb.pop = 1'b1;
          end
          default: setUnsup = 1'b1;
        endcase
        if (setUnsup) begin
          stb       = '0;
          nextState = S_HALT;
        end else begin
          fault = illegal || (needTop && stackEmpty) || (needPush && stackFull) ||
                  (isCond && !stackEmpty && topWord[WORD_W-1 -: TAG_W] != TAG_BOOL);
          taken = !isCond || (topWord[0] == condWant);
          if (fault) begin
            stb       = '0;
            setErr    = 1'b1;
            nextState = S_HALT;
          end else begin
            stb.pcStep = len + (taken ? jumpOff : '0);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_OP;
      opReg     <= '0;
      errFlag   <= 1'b0;
      unsupFlag <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_OP) opReg <= progData;
      if (setErr)   errFlag   <= 1'b1;
      if (setUnsup) unsupFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/bcData.sv
module bcData
  import bcPkg::*;
#(
  parameter int STACK_DEPTH = 8,
  localparam int SP_W   = $clog2(STACK_DEPTH + 1),
  localparam int SLOT_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  word_t            selfWord,
  input  logic             loadEn,
  input  logic [1:0]       loadSel,
  input  logic [IDX_W-1:0] loadIdx,
  input  word_t            loadData,
  output logic [PC_W-1:0]  pc,
  output word_t            topWord,
  output logic [SP_W-1:0]  depth,
  output logic             stackEmpty,
  output logic             stackFull
);
  localparam int ARR_N = 4 * (2 ** IDX_W);

  word_t stk [STACK_DEPTH];
  word_t varMem [ARR_N];
  word_t pushVal;

  assign stackEmpty = (depth == '0);
  assign stackFull  = (depth == SP_W'(STACK_DEPTH));
  assign topWord    = stackEmpty ? '0 : stk[SLOT_W'(depth - SP_W'(1))];

  always_comb begin
    case (stb.src)
      SRC_VAR:  pushVal = varMem[{stb.arrSel, stb.arrIdx}];
      SRC_TOP:  pushVal = topWord;
      SRC_SELF: pushVal = selfWord;
      default:  pushVal = stb.constWord;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc    <= '0;
      depth <= '0;
    end else begin
      if (stb.pcWe) pc <= pc + stb.pcStep;
      if (stb.push)     depth <= depth + SP_W'(1);
      else if (stb.pop) depth <= depth - SP_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.push) stk[SLOT_W'(depth)] <= pushVal;
    if (stb.arrWe)    varMem[{stb.arrSel, stb.arrIdx}] <= topWord;
    else if (loadEn)  varMem[{loadSel, loadIdx}]       <= loadData;
  end
endmodule

// File: rtl/bcExec.sv
module bcExec
  import bcPkg::*;
#(
  parameter int STACK_DEPTH = 8,
  localparam int SP_W = $clog2(STACK_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  output logic [PC_W-1:0]  progAddr,
  input  logic [7:0]       progData,
  input  logic [WORD_W-1:0] selfWord,
  input  logic             loadEn,
  input  logic [1:0]       loadSel,
  input  logic [IDX_W-1:0] loadIdx,
  input  logic [WORD_W-1:0] loadData,
  output logic [PC_W-1:0]  pc,
  output logic [WORD_W-1:0] topWord,
  output logic [SP_W-1:0]  stackDepth,
  output logic             halted,
  output logic             errFlag,
  output logic             unsupFlag
);
  strobe_t stb;
  logic inExt, stackEmpty, stackFull;

  assign progAddr = pc + PC_W'(inExt);

  bcCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .run(run), .progData(progData),
    .stackEmpty(stackEmpty), .stackFull(stackFull), .topWord(topWord),
    .stb(stb), .inExt(inExt), .halted(halted), .errFlag(errFlag), .unsupFlag(unsupFlag)
  );

  bcData #(.STACK_DEPTH(STACK_DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .stb(stb), .selfWord(selfWord),
    .loadEn(loadEn), .loadSel(loadSel), .loadIdx(loadIdx), .loadData(loadData),
    .pc(pc), .topWord(topWord), .depth(stackDepth),
    .stackEmpty(stackEmpty), .stackFull(stackFull)
  );
endmodule

// File: rtl/bcExecChecker.sv
module bcExecChecker
  import bcPkg::*;
#(
  parameter int STACK_DEPTH = 8,
  localparam int SP_W = $clog2(STACK_DEPTH + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            run,
  input logic [PC_W-1:0] pc,
  input logic [SP_W-1:0] stackDepth,
  input logic            halted,
  input logic            errFlag,
  input logic            unsupFlag
);
  // R12: a halted executor stays halted until reset
  p_halt_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted);

  // R12: frozen program counter and stack after a stop
  p_frozen_r12: assert property (@(posedge clk) disable iff (!rstN)
    $past(halted) |-> ($stable(pc) && $stable(stackDepth)));

  // R11 / R12: any fault flag means execution has stopped
  p_err_halts_r11: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag || unsupFlag) |-> halted);

  // R13: unsupported and fault stops never coincide
  p_flags_exclusive_r13: assert property (@(posedge clk) disable iff (!rstN)
    !(errFlag && unsupFlag));

  // R12: depth never exceeds the stack size
  p_depth_bound_r12: assert property (@(posedge clk) disable iff (!rstN)
    stackDepth <= SP_W'(STACK_DEPTH));

  // R7: depth moves by at most one per cycle
  p_depth_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (stackDepth == $past(stackDepth)) ||
             (stackDepth == $past(stackDepth) + SP_W'(1)) ||
             (stackDepth + SP_W'(1) == $past(stackDepth)));

  // R14: with run low nothing advances
  p_pause_r14: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> ($stable(pc) && $stable(stackDepth) && $stable(halted)));
endmodule

bind bcExec bcExecChecker #(.STACK_DEPTH(STACK_DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .run(run), .pc(pc), .stackDepth(stackDepth),
  .halted(halted), .errFlag(errFlag), .unsupFlag(unsupFlag)
);

// File: tb/bcExec_bench.sv
module bcExec_bench;
  import bcPkg::*;

  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic run = 1'b0;
  logic [PC_W-1:0] progAddr;
  logic [7:0] progData;
  logic [WORD_W-1:0] selfWord = 16'h5A5A;
  logic loadEn = 1'b0;
  logic [1:0] loadSel = '0;
  logic [IDX_W-1:0] loadIdx = '0;
  logic [WORD_W-1:0] loadData = '0;
  logic [PC_W-1:0] pc;
  logic [WORD_W-1:0] topWord;
  logic [3:0] stackDepth;
  logic halted, errFlag, unsupFlag;

  logic [7:0] progMem [2**PC_W];
  assign progData = progMem[progAddr];

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bcExec #(.STACK_DEPTH(DEPTH)) u_bcExec (
    .clk(clk), .rstN(rstN), .run(run), .progAddr(progAddr), .progData(progData),
    .selfWord(selfWord), .loadEn(loadEn), .loadSel(loadSel), .loadIdx(loadIdx),
    .loadData(loadData), .pc(pc), .topWord(topWord), .stackDepth(stackDepth),
    .halted(halted), .errFlag(errFlag), .unsupFlag(unsupFlag)
  );

  function automatic logic [15:0] pat(input int sel, input int idx);
    return {2'b01, 6'd0, 2'(sel), 6'(idx)};
  endfunction
  function automatic logic [15:0] tInt(input int v);
    return {2'b00, 14'(v)};
  endfunction

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearProg();
    for (int i = 0; i < 2**PC_W; i++) progMem[i] = 8'h7C;
  endtask

  task automatic resetDut();
    run = 1'b0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic runProg();
    run = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (halted) break;
    end
    repeat (3) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
  endtask

  task automatic expectEnd(input string req, input int ePc, input int eDepth,
                           input int eErr, input int eUnsup);
    checkEq({req, " pc"}, 32'(pc), 32'(ePc));
    checkEq({req, " depth"}, 32'(stackDepth), 32'(eDepth));
    checkEq({req, " err"}, 32'(errFlag), 32'(eErr));
    checkEq({req, " unsup"}, 32'(unsupFlag), 32'(eUnsup));
    checkEq({req, " halted"}, 32'(halted), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL R14 watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    clearProg();
    resetDut();
    // R1: reset state
    checkEq("R1 pc", 32'(pc), 0);
    checkEq("R1 depth", 32'(stackDepth), 0);
    checkEq("R1 halted", 32'(halted), 0);
    checkEq("R1 err", 32'(errFlag), 0);
    checkEq("R1 unsup", 32'(unsupFlag), 0);

    // preload every array slot with a pattern naming its array and index
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < 64; i++) begin
        loadEn = 1'b1; loadSel = 2'(s); loadIdx = 6'(i); loadData = pat(s, i);
        @(negedge clk);
      end
    loadEn = 1'b0;

    // R2: sweep every short push opcode
    for (int op = 0; op < 8'h60; op++) begin
      int s, ix;
      s  = (op < 16) ? 0 : (op < 32) ? 1 : (op < 64) ? 2 : 3;
      ix = (op < 32) ? (op & 15) : (op & 31);
      clearProg(); progMem[0] = 8'(op);
      resetDut(); runProg();
      checkEq("R2 top", 32'(topWord), 32'(pat(s, ix)));
      checkEq("R2 pc", 32'(pc), 1);
    end

    // R3: constant pushes
    for (int k = 0; k < 8; k++) begin
      logic [15:0] e;
      case (k)
        0: e = selfWord;
        1: e = 16'h8001;
        2: e = 16'h8000;
        3: e = 16'hC000;
        4: e = tInt(-1);
        default: e = tInt(k - 5);
      endcase
      clearProg(); progMem[0] = 8'h70 + 8'(k);
      resetDut(); runProg();
      checkEq("R3 const", 32'(topWord), 32'(e));
    end

    // R14: cycle count per instruction length and pause
    clearProg(); progMem[0] = 8'h80; progMem[1] = 8'h00; progMem[2] = 8'h76;
    resetDut();
    run = 1'b1; repeat (2) @(negedge clk); run = 1'b0;
    checkEq("R14 two-byte pc", 32'(pc), 2);
    checkEq("R14 two-byte depth", 32'(stackDepth), 1);
    @(negedge clk); @(negedge clk);
    checkEq("R14 pause pc", 32'(pc), 2);
    run = 1'b1; @(negedge clk); run = 1'b0;
    checkEq("R14 one-byte pc", 32'(pc), 3);
    checkEq("R14 one-byte top", 32'(topWord), 32'(tInt(1)));

    // R5: extended push of literal variable 40
    clearProg(); progMem[0] = 8'h80; progMem[1] = 8'hE8;
    resetDut(); runProg();
    checkEq("R5 ext push", 32'(topWord), 32'(pat(3, 40)));
    expectEnd("R5 ext push", 2, 1, 0, 1);

    // R4: short pop-stores then read back
    clearProg(); progMem[0] = 8'h76; progMem[1] = 8'h6A; progMem[2] = 8'h12;
    resetDut(); runProg();
    checkEq("R4 temp store", 32'(topWord), 32'(tInt(1)));
    expectEnd("R4 temp store", 3, 1, 0, 1);
    clearProg(); progMem[0] = 8'h77; progMem[1] = 8'h62; progMem[2] = 8'h02;
    resetDut(); runProg();
    checkEq("R4 rcv store", 32'(topWord), 32'(tInt(2)));
    expectEnd("R4 rcv store", 3, 1, 0, 1);

    // R5: store keeping top, then push it back
    clearProg(); progMem[0] = 8'h77; progMem[1] = 8'h81; progMem[2] = 8'h72;
    progMem[3] = 8'h80; progMem[4] = 8'h72;
    resetDut(); runProg();
    checkEq("R5 store keep", 32'(topWord), 32'(tInt(2)));
    expectEnd("R5 store keep", 5, 2, 0, 1);
    // R5: store and pop into receiver 33
    clearProg(); progMem[0] = 8'h75; progMem[1] = 8'h82; progMem[2] = 8'h21;
    progMem[3] = 8'h80; progMem[4] = 8'h21;
    resetDut(); runProg();
    checkEq("R5 store pop", 32'(topWord), 32'(tInt(0)));
    expectEnd("R5 store pop", 5, 1, 0, 1);

    // R6: literal-constant selector on a store
    clearProg(); progMem[0] = 8'h76; progMem[1] = 8'h81; progMem[2] = 8'h85;
    resetDut(); runProg();
    expectEnd("R6 illegal sel", 1, 1, 1, 0);
    checkEq("R6 top kept", 32'(topWord), 32'(tInt(1)));

    // R7: duplicate and drop
    clearProg(); progMem[0] = 8'h76; progMem[1] = 8'h77; progMem[2] = 8'h88; progMem[3] = 8'h87;
    resetDut(); runProg();
    checkEq("R7 dup drop", 32'(topWord), 32'(tInt(2)));
    expectEnd("R7 dup drop", 4, 2, 0, 1);
    clearProg(); progMem[0] = 8'h76; progMem[1] = 8'h88;
    resetDut(); runProg();
    checkEq("R7 dup", 32'(topWord), 32'(tInt(1)));
    expectEnd("R7 dup", 2, 2, 0, 1);

    // R8: short jumps
    clearProg(); progMem[0] = 8'h93; progMem[5] = 8'h76;
    resetDut(); runProg();
    expectEnd("R8 jump", 6, 1, 0, 1);
    clearProg(); progMem[0] = 8'h72; progMem[1] = 8'h98; progMem[3] = 8'h7D;
    resetDut(); runProg();
    expectEnd("R8 cond taken", 3, 0, 0, 1);
    clearProg(); progMem[0] = 8'h71; progMem[1] = 8'h98;
    resetDut(); runProg();
    expectEnd("R8 cond not taken", 2, 0, 0, 1);

    // R9: long jumps forward then backward
    clearProg(); progMem[0] = 8'hA4; progMem[1] = 8'h03; progMem[5] = 8'h76;
    progMem[6] = 8'hA3; progMem[7] = 8'hFB; progMem[3] = 8'h7E;
    resetDut(); runProg();
    expectEnd("R9 backward", 3, 1, 0, 1);
    clearProg(); progMem[0] = 8'hA5; progMem[1] = 8'h10; progMem[274] = 8'h77;
    resetDut(); runProg();
    checkEq("R9 far top", 32'(topWord), 32'(tInt(2)));
    expectEnd("R9 far", 275, 1, 0, 1);

    // R10: long conditional jumps
    clearProg(); progMem[0] = 8'h71; progMem[1] = 8'hA9; progMem[2] = 8'h02;
    resetDut(); runProg();
    expectEnd("R10 true taken", 261, 0, 0, 1);
    clearProg(); progMem[0] = 8'h72; progMem[1] = 8'hAC; progMem[2] = 8'h04;
    resetDut(); runProg();
    expectEnd("R10 false taken", 7, 0, 0, 1);
    clearProg(); progMem[0] = 8'h71; progMem[1] = 8'hAC; progMem[2] = 8'h04;
    resetDut(); runProg();
    expectEnd("R10 not taken", 3, 0, 0, 1);

    // R11: conditional on an integer
    clearProg(); progMem[0] = 8'h76; progMem[1] = 8'h98;
    resetDut(); runProg();
    expectEnd("R11 non-bool", 1, 1, 1, 0);

    // R12: underflow and overflow
    clearProg(); progMem[0] = 8'h87;
    resetDut(); runProg();
    expectEnd("R12 underflow", 0, 0, 1, 0);
    clearProg();
    for (int i = 0; i <= DEPTH; i++) progMem[i] = 8'h75;
    resetDut(); runProg();
    expectEnd("R12 overflow", DEPTH, DEPTH, 1, 0);

    // R13: sweep every unsupported opcode
    for (int op = 0; op < 256; op++) begin
      if ((op >= 8'h78 && op <= 8'h7F) || (op >= 8'h83 && op <= 8'h86) ||
          (op >= 8'h89 && op <= 8'h8F) || op >= 8'hB0) begin
        clearProg(); progMem[0] = 8'(op);
        resetDut(); runProg();
        checkEq("R13 unsup flag", 32'(unsupFlag), 1);
        checkEq("R13 pc", 32'(pc), 0);
        checkEq("R13 err clear", 32'(errFlag), 0);
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule